// File: doc/BRIEF.md
# Delta Quiescent-Current Screen

This block judges a device under test from a stream of digitized quiescent supply current readings, one reading for each applied test vector. In delta mode each accepted reading is compared with the reading accepted just before it. The magnitude of that change is checked against a programmable threshold. Judging the step between vectors, instead of the level, removes the offset that varies from die to die and from wafer to wafer. In absolute mode the raw reading is checked against a fixed limit register instead.

Each accepted reading produces a registered per-vector fail flag. The first failure sets a sticky device-fail flag and a latched breaker trip output. It also captures the zero-based index of the failing vector. All of these hold until a synchronous clear or the asynchronous reset.

A three-state controller tracks the history. ST_EMPTY means no predecessor reading exists. ST_ARMED means a predecessor exists and nothing has failed. ST_TRIPPED means a failure has been seen. The transitions are as follows:
- ST_EMPTY to ST_ARMED on an accepted passing reading.
- ST_EMPTY to ST_TRIPPED on an accepted reading that fails, which can only happen in absolute mode.
- ST_ARMED to ST_TRIPPED on an accepted failing reading.
- Any state to ST_EMPTY on clear.
- ST_TRIPPED holds otherwise.

Top module: `qcur_delta_screen`

## Requirements
- R1: After reset or a synchronous clear, the outputs `vec_fail`, `dev_fail` and `trip` are low and `first_fail_idx` is 0. The next accepted reading is treated as the first one, with no predecessor.
- R2: In delta mode (`mode_abs`=0), an accepted reading fails when the absolute value of the signed difference (reading minus previous accepted reading) is greater than `delta_thr`. The difference is computed one bit wider than the reading.
- R3: A difference whose magnitude equals `delta_thr` exactly passes.
- R4: In delta mode, the first accepted reading after reset or clear never fails, whatever its value.
- R5: In absolute mode (`mode_abs`=1), an accepted reading fails when it is greater than `abs_limit`, including the first reading after a clear. A reading equal to the limit passes.
- R6: A reading is accepted only when `smp_valid` is high. The stored previous reading changes only on accepted readings, so an unaccepted reading affects no later result.
- R7: `vec_fail` is high for exactly the one cycle after the clock edge that accepted a failing reading. It is low after any edge with no accepted reading.
- R8: `dev_fail` and `trip` rise together with the first `vec_fail`. They stay high through later passing readings until a clear.
- R9: `first_fail_idx` captures the zero-based count of accepted readings since the last clear at the first failure. Later failures leave it unchanged. The count saturates at 2^CNT_W-1.
- R10: When `clear` and `smp_valid` are high in the same cycle, the clear wins and the reading is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; readings are taken at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of history, flags, trip and index |
| smp_valid | input | 1 | Reading on `smp_code` is offered this cycle |
| smp_code | input | DATA_W | Unsigned current reading |
| delta_thr | input | DATA_W | Delta-mode decision threshold |
| abs_limit | input | DATA_W | Absolute-mode current limit |
| mode_abs | input | 1 | 1 = absolute mode, 0 = delta mode |
| vec_fail | output | 1 | Previous accepted reading failed |
| dev_fail | output | 1 | Sticky device failure flag |
| trip | output | 1 | Latched breaker trip |
| first_fail_idx | output | CNT_W | Index of the first failing vector |

## Verification
Every result is registered at the edge that accepts the reading, so `vec_fail`, `dev_fail`, `trip` and `first_fail_idx` are all due one cycle after the stimulus. Stimulus is driven at the falling edge, and all four outputs are compared one time unit after the next rising edge. The expected values come from an arithmetic model in the bench, which is updated only at those edges. The bench sweeps every previous/current pair of a 6-bit configuration against several thresholds, and every reading against several absolute limits. Directed sequences then cover unaccepted readings, clear priority, stickiness and index saturation.

// File: rtl/qcur_pkg.sv
package qcur_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_ARMED   = 2'd1,
        ST_TRIPPED = 2'd2
    } qstate_e;
endpackage

// File: rtl/qcur_history.sv
module qcur_history #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  logic [DATA_W-1:0] code,
    output logic [DATA_W-1:0] prev_code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      prev_code <= '0;
        else if (clear)  prev_code <= '0;
        else if (accept) prev_code <= code;
    end

    // R6: load on accepted readings only
    assert_prev_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (prev_code == $past(code)));
    assert_prev_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !clear) |=> $stable(prev_code));
endmodule

// File: rtl/qcur_judge.sv
module qcur_judge #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] code,
    input  logic [DATA_W-1:0] prev_code,
    input  logic              have_prev,
    input  logic [DATA_W-1:0] delta_thr,
    input  logic [DATA_W-1:0] abs_limit,
    input  logic              mode_abs,
    output logic              fail_now
);
    localparam int DIFF_W = DATA_W + 1;

    logic signed [DIFF_W-1:0] diff;
    logic        [DIFF_W-1:0] mag;
    logic                     over_delta;
    logic                     over_abs;

    always_comb begin
        diff       = $signed({1'b0, code}) - $signed({1'b0, prev_code});
        mag        = diff[DIFF_W-1] ? $unsigned(-diff) : $unsigned(diff);
        over_delta = mag > {1'b0, delta_thr};
        over_abs   = code > abs_limit;
        fail_now   = mode_abs ? over_abs : (have_prev && over_delta);
    end
endmodule

// File: rtl/qcur_fail_fsm.sv
module qcur_fail_fsm
    import qcur_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic accept,
    input  logic fail_now,
    input  logic mode_abs,
    output logic have_prev,
    output logic vec_fail,
    output logic dev_fail,
    output logic trip
);
    qstate_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (clear) begin
            state_nx = ST_EMPTY;
        end else begin
            unique case (state)
                ST_EMPTY:   if (accept) state_nx = fail_now ? ST_TRIPPED : ST_ARMED;
                ST_ARMED:   if (accept && fail_now) state_nx = ST_TRIPPED;
                ST_TRIPPED: state_nx = ST_TRIPPED;
                default:    state_nx = ST_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_fail <= 1'b0;
            dev_fail <= 1'b0;
        end else if (clear) begin
            vec_fail <= 1'b0;
            dev_fail <= 1'b0;
        end else begin
            vec_fail <= accept && fail_now;
            if (accept && fail_now) dev_fail <= 1'b1;
        end
    end

    assign have_prev = (state != ST_EMPTY);
    assign trip      = (state == ST_TRIPPED);

    assert_no_first_delta_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY && !mode_abs) |-> !fail_now);
    assert_clear_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!trip && !dev_fail && !vec_fail));
    assert_trip_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !clear) |=> trip);
    assert_sticky_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fail |-> (dev_fail && trip));
    assert_vec_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !vec_fail);
endmodule

// File: rtl/qcur_vec_index.sv
module qcur_vec_index #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic             fail_now,
    input  logic             dev_fail,
    output logic [CNT_W-1:0] first_fail_idx
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt            <= '0;
            first_fail_idx <= '0;
        end else if (clear) begin
            cnt            <= '0;
            first_fail_idx <= '0;
        end else if (accept) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (fail_now && !dev_fail) first_fail_idx <= cnt;
        end
    end

    assert_idx_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && accept) |=> (cnt == CNT_MAX));
    assert_first_idx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_fail && !clear) |=> $stable(first_fail_idx));
endmodule

// File: rtl/qcur_delta_screen.sv
module qcur_delta_screen #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_code,
    input  logic [DATA_W-1:0] delta_thr,
    input  logic [DATA_W-1:0] abs_limit,
    input  logic              mode_abs,
    output logic              vec_fail,
    output logic              dev_fail,
    output logic              trip,
    output logic [CNT_W-1:0]  first_fail_idx
);
    logic              accept;
    logic              have_prev;
    logic              fail_now;
    logic [DATA_W-1:0] prev_code;

    assign accept = smp_valid && !clear;   // R10: clear wins

    qcur_history #(.DATA_W(DATA_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .clear(clear), .accept(accept),
        .code(smp_code), .prev_code(prev_code)
    );

    qcur_judge #(.DATA_W(DATA_W)) u_judge (
        .code(smp_code), .prev_code(prev_code), .have_prev(have_prev),
        .delta_thr(delta_thr), .abs_limit(abs_limit), .mode_abs(mode_abs),
        .fail_now(fail_now)
    );

    qcur_fail_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clear(clear), .accept(accept),
        .fail_now(fail_now), .mode_abs(mode_abs), .have_prev(have_prev),
        .vec_fail(vec_fail), .dev_fail(dev_fail), .trip(trip)
    );

    qcur_vec_index #(.CNT_W(CNT_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .clear(clear), .accept(accept),
        .fail_now(fail_now), .dev_fail(dev_fail), .first_fail_idx(first_fail_idx)
    );

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && smp_valid) |=> (!vec_fail && first_fail_idx == '0));
endmodule

// File: tb/tb_qcur_delta_screen.sv
module tb_qcur_delta_screen;
    localparam int DW   = 6;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;
    localparam int VMAX = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_code = '0;
    logic [DW-1:0] delta_thr = '0;
    logic [DW-1:0] abs_limit = '0;
    logic          mode_abs = 1'b0;
    logic          vec_fail, dev_fail, trip;
    logic [CW-1:0] first_fail_idx;

    always #5 clk = ~clk;

    qcur_delta_screen #(.DATA_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .smp_valid(smp_valid),
        .smp_code(smp_code), .delta_thr(delta_thr), .abs_limit(abs_limit),
        .mode_abs(mode_abs), .vec_fail(vec_fail), .dev_fail(dev_fail),
        .trip(trip), .first_fail_idx(first_fail_idx)
    );

    int n_chk = 0;
    int n_bad = 0;
    int m_prev = 0;
    bit m_have = 0;
    bit m_dev = 0;
    int m_idx = 0;
    int m_ffi = 0;

    task automatic check(input string tag, input bit e_vf);
        n_chk++;
        if (vec_fail !== e_vf || dev_fail !== m_dev || trip !== m_dev ||
            first_fail_idx !== CW'(m_ffi)) begin
            n_bad++;
            $display("FAIL %s: vf/dev/trip/idx got %b/%b/%b/%0d expected %b/%b/%b/%0d",
                     tag, vec_fail, dev_fail, trip, first_fail_idx,
                     e_vf, m_dev, m_dev, m_ffi);
        end
    endtask

    task automatic step(input bit v, input int code, input bit clr, input string tag);
        bit e_vf;
        int d;
        @(negedge clk);
        smp_valid = v;
        smp_code  = DW'(code);
        clear     = clr;
        @(posedge clk);
        #1;
        e_vf = 1'b0;
        if (clr) begin
            m_have = 0; m_dev = 0; m_idx = 0; m_ffi = 0; m_prev = 0;
        end else if (v) begin
            d = code - m_prev;
            if (d < 0) d = -d;
            if (mode_abs) e_vf = code > int'(abs_limit);
            else          e_vf = m_have && (d > int'(delta_thr));
            if (e_vf && !m_dev) begin m_dev = 1; m_ffi = m_idx; end
            if (m_idx < CMAX) m_idx++;
            m_prev = code;
            m_have = 1;
        end
        check(tag, e_vf);
    endtask

    initial begin
        #(10 * 200000);
        n_bad++;
        $display("FAIL R7 watchdog: got no finish expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int thr_set[3];
        int lim_set[3];
        thr_set = '{0, 7, VMAX};
        lim_set = '{0, 20, VMAX};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", 1'b0);

        // delta-mode sweep over every (previous, current) pair
        mode_abs = 1'b0;
        for (int t = 0; t < 3; t++) begin
            delta_thr = DW'(thr_set[t]);
            for (int a = 0; a <= VMAX; a++) begin
                for (int b = 0; b <= VMAX; b++) begin
                    int d;
                    step(1'b1, b, 1'b1, "R10");
                    step(1'b1, a, 1'b0, "R4");
                    d = (b > a) ? b - a : a - b;
                    if (d == thr_set[t]) step(1'b1, b, 1'b0, "R3");
                    else                 step(1'b1, b, 1'b0, "R2");
                end
            end
        end

        // absolute-mode sweep, first reading after clear
        mode_abs = 1'b1;
        for (int l = 0; l < 3; l++) begin
            abs_limit = DW'(lim_set[l]);
            for (int c = 0; c <= VMAX; c++) begin
                step(1'b0, 0, 1'b1, "R1");
                step(1'b1, c, 1'b0, "R5");
            end
        end

        // unaccepted readings, pulse width, stickiness, first index
        mode_abs  = 1'b0;
        delta_thr = DW'(2);
        step(1'b0, 0, 1'b1, "R1");
        step(1'b1, 10, 1'b0, "R4");
        step(1'b0, 60, 1'b0, "R6");
        step(1'b1, 11, 1'b0, "R6");
        step(1'b1, 50, 1'b0, "R2");
        step(1'b0, 0, 1'b0, "R7");
        step(1'b1, 51, 1'b0, "R8");
        step(1'b1, 52, 1'b0, "R8");
        step(1'b1, 0, 1'b0, "R9");
        step(1'b1, 40, 1'b1, "R10");
        step(1'b1, 40, 1'b0, "R1");

        // index saturation
        delta_thr = DW'(VMAX);
        step(1'b0, 0, 1'b1, "R1");
        for (int k = 0; k < CMAX + 5; k++) step(1'b1, 5, 1'b0, "R9");
        delta_thr = '0;
        step(1'b1, 6, 1'b0, "R9");
        step(1'b1, 6, 1'b0, "R7");
        step(1'b1, 9, 1'b0, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule